// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block decides whether the address phase of an I2C transfer selects the local slave. A byte shifter hands it each received byte with a one-cycle strobe, and the bus monitor signals START (or repeated START) and STOP conditions. The matcher compares the first byte, and in 10-bit mode the second byte as well, against a configured own address. The same comparison is also made against an optional secondary upper address, an optional inclusive address window, and the general call address.

On a hit the block raises an ACK request for that address byte and a one-cycle match pulse. It also holds three level flags until the next START or STOP: selected-as-slave, selected-through-the-window, and the transfer direction seen from the slave. In 10-bit mode, a slave already selected by a 10-bit write is selected again for a read by a repeated START. That START needs only a header byte with the read bit set and no second byte. Serial bit timing and the data phase belong to the surrounding controller.

Top module: `i2c_slv_addr_match`

## Requirements
- R1: After reset, addr_match, slave_sel, range_flag, slave_tx and ack_req are all 0.
- R2: In 7-bit mode, a first byte after START whose bits 7:1 equal own_addr[6:0] gives ack_req=1 and addr_match=1 in the cycle after its strobe. slave_sel then goes to 1, and slave_tx takes bit 0 of that byte (1 = master reads, slave transmits).
- R3: A nonzero upper_addr is a second 7-bit address that selects the slave with range_flag=0 when the range window is off. An upper_addr of 0 matches nothing.
- R4: With range_en=1, own_addr nonzero and upper_addr nonzero, any address from own_addr up to upper_addr, both ends included, selects the slave and sets range_flag=1. If either bound is zero or range_en=0, the window matches nothing.
- R5: The byte 0x00 selects the slave only when gcall_en=1. It gives slave_tx=0 and range_flag=0. The byte 0x01 is never a general call.
- R6: In 10-bit mode, a first byte equal to 11110 followed by own_addr[9:8] and a 0 read bit is acknowledged without selecting the slave. A following byte equal to own_addr[7:0] selects the slave with slave_tx=0.
- R7: In 10-bit mode, the upper bound is the 10-bit value {own_addr[9:7], upper_addr}. It is used both for the secondary match and for the window on the second byte.
- R8: After a 10-bit write selection, a repeated START followed by the header byte with the read bit set selects the slave at once, with slave_tx=1 and an ACK. After a STOP, that header byte alone matches nothing.
- R9: The cycle after any START or STOP, slave_sel, range_flag and slave_tx are 0.
- R10: A non-matching address byte gives no ACK and no selection. Bytes after the address phase give no ACK and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ten_bit_mode | input | 1 | 1 selects 10-bit own address |
| own_addr | input | 10 | Own address, right-aligned; 7-bit mode uses bits 6:0 |
| upper_addr | input | 7 | Secondary / window upper address; 0 disables |
| range_en | input | 1 | Enables the inclusive address window |
| gcall_en | input | 1 | Enables general call recognition |
| bus_start | input | 1 | One-cycle pulse on START or repeated START |
| bus_stop | input | 1 | One-cycle pulse on STOP |
| byte_valid | input | 1 | One-cycle strobe for a received byte |
| byte_data | input | 8 | Received byte |
| addr_match | output | 1 | Pulse: address phase completed with a hit |
| slave_sel | output | 1 | Addressed-as-slave flag |
| range_flag | output | 1 | Selection came through the address window |
| slave_tx | output | 1 | 1 = slave transmits (master reading) |
| ack_req | output | 1 | Pulse: acknowledge the byte just received |

## Verification
The assertions assume that START, STOP and the byte strobe never arrive in the same cycle. They also assume that two strobes are never back to back, because every byte takes many clock cycles on a real bus, and that the configuration inputs stay still during an address phase. The bench keeps to these assumptions. It changes configuration only while the bus is idle, pulses START or STOP on its own, and leaves an idle cycle after every strobe before it checks the flags.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int ADDR7_W  = 7;
  localparam int ADDR10_W = 10;
  localparam int BYTE_W   = 8;
  localparam int HI_W     = ADDR10_W - BYTE_W;
  localparam logic [4:0] TEN_PREFIX = 5'b11110;

  typedef enum logic [1:0] {PH_IDLE, PH_FIRST, PH_SECOND} phase_t;

  // Upper seven bits of a 10-bit header byte for given high address bits.
  function automatic logic [ADDR7_W-1:0] ten_header(input logic [HI_W-1:0] hi);
    return {TEN_PREFIX, hi};
  endfunction

  // General call: all-zero byte, write direction.
  function automatic logic is_gcall(input logic [BYTE_W-1:0] b);
    return b == '0;
  endfunction
endpackage

// File: rtl/i2c_slv_cmp.sv
module i2c_slv_cmp #(
  parameter int W = 7
) (
  input  logic [W-1:0] cand,
  input  logic [W-1:0] prim,
  input  logic [W-1:0] upper,
  input  logic         upper_on,
  input  logic         range_en,
  output logic         any_hit,
  output logic         in_range
);
  logic prim_hit, upper_hit, prim_on;

  always_comb begin
    prim_on   = |prim;
    prim_hit  = (cand == prim);
    upper_hit = upper_on && (cand == upper);
    in_range  = range_en && prim_on && upper_on && (cand >= prim) && (cand <= upper);
    any_hit   = prim_hit || upper_hit || in_range;
  end
endmodule

// File: rtl/i2c_slv_phase.sv
module i2c_slv_phase
  import i2c_slv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ten_bit_mode,
  input  logic bus_start,
  input  logic bus_stop,
  input  logic byte_valid,
  input  logic rw_bit,
  input  logic gc_hit,
  input  logic hit7,
  input  logic rng7,
  input  logic hdr_ok,
  input  logic hit10,
  input  logic rng10,
  output logic addr_match,
  output logic slave_sel,
  output logic range_flag,
  output logic slave_tx,
  output logic ack_req
);
  phase_t phase;
  logic   armed, armed_rng;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      armed      <= 1'b0;
      armed_rng  <= 1'b0;
      addr_match <= 1'b0;
      slave_sel  <= 1'b0;
      range_flag <= 1'b0;
      slave_tx   <= 1'b0;
      ack_req    <= 1'b0;
    end else begin
      ack_req    <= 1'b0;
      addr_match <= 1'b0;
      if (bus_start || bus_stop) begin
        phase      <= bus_start ? PH_FIRST : PH_IDLE;
        slave_sel  <= 1'b0;
        range_flag <= 1'b0;
        slave_tx   <= 1'b0;
        if (bus_stop) armed <= 1'b0;
      end else if (byte_valid) begin
        unique case (phase)
          PH_FIRST: begin
            phase <= PH_IDLE;
            if (gc_hit) begin
              slave_sel  <= 1'b1;
              ack_req    <= 1'b1;
              addr_match <= 1'b1;
            end else if (!ten_bit_mode) begin
              if (hit7) begin
                slave_sel  <= 1'b1;
                ack_req    <= 1'b1;
                addr_match <= 1'b1;
                slave_tx   <= rw_bit;
                range_flag <= rng7;
              end
            end else if (hdr_ok && !rw_bit) begin
              ack_req <= 1'b1;
              armed   <= 1'b0;
              phase   <= PH_SECOND;
            end else if (hdr_ok && armed) begin
              slave_sel  <= 1'b1;
              ack_req    <= 1'b1;
              addr_match <= 1'b1;
              slave_tx   <= 1'b1;
              range_flag <= armed_rng;
            end
          end
          PH_SECOND: begin
            phase <= PH_IDLE;
            if (hit10) begin
              slave_sel  <= 1'b1;
              ack_req    <= 1'b1;
              addr_match <= 1'b1;
              range_flag <= rng10;
              armed      <= 1'b1;
              armed_rng  <= rng10;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_slv_addr_match.sv
module i2c_slv_addr_match
  import i2c_slv_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ten_bit_mode,
  input  logic [ADDR10_W-1:0] own_addr,
  input  logic [ADDR7_W-1:0]  upper_addr,
  input  logic                range_en,
  input  logic                gcall_en,
  input  logic                bus_start,
  input  logic                bus_stop,
  input  logic                byte_valid,
  input  logic [BYTE_W-1:0]   byte_data,
  output logic                addr_match,
  output logic                slave_sel,
  output logic                range_flag,
  output logic                slave_tx,
  output logic                ack_req
);
  logic                upper_on, gc_hit, hdr_ok;
  logic                hit7, rng7, hit10, rng10;
  logic [ADDR10_W-1:0] upper10, cand10;

  assign upper_on = |upper_addr;
  assign gc_hit   = gcall_en && is_gcall(byte_data);
  assign hdr_ok   = byte_data[BYTE_W-1:1] == ten_header(own_addr[ADDR10_W-1 -: HI_W]);
  assign upper10  = {own_addr[ADDR10_W-1:ADDR7_W], upper_addr};
  assign cand10   = {own_addr[ADDR10_W-1 -: HI_W], byte_data};

  i2c_slv_cmp #(.W(ADDR7_W)) i_cmp7 (
    .cand     (byte_data[BYTE_W-1:1]),
    .prim     (own_addr[ADDR7_W-1:0]),
    .upper    (upper_addr),
    .upper_on (upper_on),
    .range_en (range_en),
    .any_hit  (hit7),
    .in_range (rng7)
  );

  i2c_slv_cmp #(.W(ADDR10_W)) i_cmp10 (
    .cand     (cand10),
    .prim     (own_addr),
    .upper    (upper10),
    .upper_on (upper_on),
    .range_en (range_en),
    .any_hit  (hit10),
    .in_range (rng10)
  );

  i2c_slv_phase i_phase (
    .clk          (clk),
    .rst_n        (rst_n),
    .ten_bit_mode (ten_bit_mode),
    .bus_start    (bus_start),
    .bus_stop     (bus_stop),
    .byte_valid   (byte_valid),
    .rw_bit       (byte_data[0]),
    .gc_hit       (gc_hit),
    .hit7         (hit7),
    .rng7         (rng7),
    .hdr_ok       (hdr_ok),
    .hit10        (hit10),
    .rng10        (rng10),
    .addr_match   (addr_match),
    .slave_sel    (slave_sel),
    .range_flag   (range_flag),
    .slave_tx     (slave_tx),
    .ack_req      (ack_req)
  );
endmodule

// File: rtl/i2c_slv_addr_match_chk.sv
module i2c_slv_addr_match_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_start,
  input logic bus_stop,
  input logic byte_valid,
  input logic addr_match,
  input logic slave_sel,
  input logic range_flag,
  input logic slave_tx,
  input logic ack_req
);
  AST_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> $past(byte_valid)); // R10
  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start || bus_stop) |=> (!slave_sel && !range_flag && !slave_tx)); // R9
  AST_RANGE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    range_flag |-> slave_sel); // R4
  AST_TX_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    slave_tx |-> slave_sel); // R2
  AST_SEL_BY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slave_sel) |-> addr_match); // R2
  AST_MATCH_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match |-> ack_req); // R6
endmodule

bind i2c_slv_addr_match i2c_slv_addr_match_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_start  (bus_start),
  .bus_stop   (bus_stop),
  .byte_valid (byte_valid),
  .addr_match (addr_match),
  .slave_sel  (slave_sel),
  .range_flag (range_flag),
  .slave_tx   (slave_tx),
  .ack_req    (ack_req)
);

// File: tb/test_i2c_slv_addr_match.sv
`timescale 1ns/1ps
module test_i2c_slv_addr_match;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ten_bit_mode = 1'b0;
  logic [9:0] own_addr = '0;
  logic [6:0] upper_addr = '0;
  logic       range_en = 1'b0;
  logic       gcall_en = 1'b0;
  logic       bus_start = 1'b0;
  logic       bus_stop = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic       addr_match, slave_sel, range_flag, slave_tx, ack_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_slv_addr_match i_i2c_slv_addr_match (
    .clk(clk), .rst_n(rst_n), .ten_bit_mode(ten_bit_mode), .own_addr(own_addr),
    .upper_addr(upper_addr), .range_en(range_en), .gcall_en(gcall_en),
    .bus_start(bus_start), .bus_stop(bus_stop), .byte_valid(byte_valid),
    .byte_data(byte_data), .addr_match(addr_match), .slave_sel(slave_sel),
    .range_flag(range_flag), .slave_tx(slave_tx), .ack_req(ack_req)
  );

  task automatic chk(input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic edge_pulse(input bit is_start, input string req);
    @(negedge clk);
    bus_start = is_start;
    bus_stop  = !is_start;
    @(negedge clk);
    bus_start = 1'b0;
    bus_stop  = 1'b0;
    chk({req, " slave_sel cleared"}, slave_sel, 1'b0);
    chk({req, " range_flag cleared"}, range_flag, 1'b0);
    chk({req, " slave_tx cleared"}, slave_tx, 1'b0);
  endtask

  task automatic put_byte(input logic [7:0] b, input logic e_ack, input logic e_match,
                          input logic e_sel, input logic e_tx, input logic e_rng,
                          input string req);
    @(negedge clk);
    byte_valid = 1'b1;
    byte_data  = b;
    @(negedge clk);
    byte_valid = 1'b0;
    chk({req, " ack_req"}, ack_req, e_ack);
    chk({req, " addr_match"}, addr_match, e_match);
    @(negedge clk);
    chk({req, " ack_req one cycle"}, ack_req, 1'b0);
    chk({req, " slave_sel"}, slave_sel, e_sel);
    chk({req, " slave_tx"}, slave_tx, e_tx);
    chk({req, " range_flag"}, range_flag, e_rng);
  endtask

  task automatic cfg(input logic ten, input logic [9:0] own, input logic [6:0] up,
                     input logic rng, input logic gc);
    @(negedge clk);
    ten_bit_mode = ten; own_addr = own; upper_addr = up; range_en = rng; gcall_en = gc;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 addr_match", addr_match, 1'b0);
    chk("R1 slave_sel", slave_sel, 1'b0);
    chk("R1 range_flag", range_flag, 1'b0);
    chk("R1 slave_tx", slave_tx, 1'b0);
    chk("R1 ack_req", ack_req, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_seven_bit;
    cfg(1'b0, 10'h02A, 7'h00, 1'b0, 1'b0);
    edge_pulse(1'b1, "R9");
    put_byte(8'h54, 1, 1, 1, 0, 0, "R2 write");
    put_byte(8'h54, 0, 0, 1, 0, 0, "R10 data ignored");
    edge_pulse(1'b1, "R9 restart");
    put_byte(8'h55, 1, 1, 1, 1, 0, "R2 read");
    edge_pulse(1'b0, "R9 stop");
    edge_pulse(1'b1, "R9");
    put_byte(8'h56, 0, 0, 0, 0, 0, "R10 miss");
  endtask

  task automatic t_upper;
    cfg(1'b0, 10'h02A, 7'h38, 1'b0, 1'b0);
    edge_pulse(1'b1, "R9");
    put_byte(8'h70, 1, 1, 1, 0, 0, "R3 upper hit");
    cfg(1'b0, 10'h02A, 7'h00, 1'b0, 1'b0);
    edge_pulse(1'b1, "R9");
    put_byte(8'h00, 0, 0, 0, 0, 0, "R3 upper zero off");
  endtask

  task automatic t_range;
    cfg(1'b0, 10'h02A, 7'h30, 1'b1, 1'b0);
    edge_pulse(1'b1, "R9");
    put_byte(8'h58, 1, 1, 1, 0, 1, "R4 inside");
    edge_pulse(1'b1, "R9");
    put_byte(8'h60, 1, 1, 1, 0, 1, "R4 top end");
    edge_pulse(1'b1, "R9");
    put_byte(8'h55, 1, 1, 1, 1, 1, "R4 bottom end read");
    edge_pulse(1'b1, "R9");
    put_byte(8'h62, 0, 0, 0, 0, 0, "R4 above");
    cfg(1'b0, 10'h02A, 7'h30, 1'b0, 1'b0);
    edge_pulse(1'b1, "R9");
    put_byte(8'h58, 0, 0, 0, 0, 0, "R4 window off");
    cfg(1'b0, 10'h000, 7'h30, 1'b1, 1'b0);
    edge_pulse(1'b1, "R9");
    put_byte(8'h58, 0, 0, 0, 0, 0, "R4 zero lower bound");
  endtask

  task automatic t_gcall;
    cfg(1'b0, 10'h02A, 7'h00, 1'b0, 1'b0);
    edge_pulse(1'b1, "R9");
    put_byte(8'h00, 0, 0, 0, 0, 0, "R5 gcall disabled");
    cfg(1'b0, 10'h02A, 7'h00, 1'b0, 1'b1);
    edge_pulse(1'b1, "R9");
    put_byte(8'h00, 1, 1, 1, 0, 0, "R5 gcall");
    edge_pulse(1'b1, "R9");
    put_byte(8'h01, 0, 0, 0, 0, 0, "R5 gcall read bit");
  endtask

  task automatic t_ten_bit;
    cfg(1'b1, 10'h2B5, 7'h00, 1'b0, 1'b0);
    edge_pulse(1'b1, "R9");
    put_byte(8'hF4, 1, 0, 0, 0, 0, "R6 header");
    put_byte(8'hB5, 1, 1, 1, 0, 0, "R6 low byte");
    edge_pulse(1'b1, "R9 restart");
    put_byte(8'hF5, 1, 1, 1, 1, 0, "R8 reselect read");
    edge_pulse(1'b0, "R9 stop");
    edge_pulse(1'b1, "R9");
    put_byte(8'hF5, 0, 0, 0, 0, 0, "R8 not armed");
    edge_pulse(1'b1, "R9");
    put_byte(8'hF2, 0, 0, 0, 0, 0, "R6 wrong header");
    edge_pulse(1'b1, "R9");
    put_byte(8'hF4, 1, 0, 0, 0, 0, "R6 header");
    put_byte(8'hB4, 0, 0, 0, 0, 0, "R6 wrong low byte");
  endtask

  task automatic t_ten_upper;
    cfg(1'b1, 10'h2B5, 7'h3F, 1'b0, 1'b0);
    edge_pulse(1'b1, "R9");
    put_byte(8'hF4, 1, 0, 0, 0, 0, "R7 header");
    put_byte(8'hBF, 1, 1, 1, 0, 0, "R7 upper hit");
    cfg(1'b1, 10'h2B5, 7'h3F, 1'b1, 1'b0);
    edge_pulse(1'b1, "R9");
    put_byte(8'hF4, 1, 0, 0, 0, 0, "R7 header");
    put_byte(8'hBA, 1, 1, 1, 0, 1, "R7 window");
    edge_pulse(1'b1, "R9");
    put_byte(8'hF4, 1, 0, 0, 0, 0, "R7 header");
    put_byte(8'hC0, 0, 0, 0, 0, 0, "R7 above window");
  endtask

  initial begin
    t_reset();
    t_seven_bit();
    t_upper();
    t_range();
    t_gcall();
    t_ten_bit();
    t_ten_upper();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule